// File: doc/BRIEF.md
# Packed-Decimal to Binary Converter

This block turns a number held as packed decimal digits (four bits per digit, least significant digit in the lowest nibble) into its plain binary value. It runs the shift-and-add-three decimal conversion backwards. A purely combinational array of stages moves the digit field right one bit at a time. Each bit that leaves the bottom of the field becomes the next binary result bit, lowest first. After each shift, a correction cell on every digit lowers any nibble of eight or more by three.

The default build takes five digits and yields a 17-bit result. There is exactly one clock of latency from the input to the result. A parameter places the single register rank either in front of the array or behind it. An invalid flag is raised when any nibble holds a value above nine. The binary output is then of no meaning.

Top module: `bcd_to_bin_conv`

## Requirements
- R1: For every input whose nibbles all lie in 0 to 9, `bin_o` equals the decimal value of the input, where nibble k has weight 10^k. For the default of five digits this covers 0 to 99999.
- R2: `bin_o` and `invalid_o` reflect the `bcd_i` value sampled at the previous rising edge of `clk`. They hold steady between edges, whatever `bcd_i` does in the meantime.
- R3: `invalid_o` is 1 one cycle after any nibble of `bcd_i` holds a value from 10 to 15. It is 0 one cycle after an input whose nibbles are all 9 or less.
- R4: While `rst_n` is low, `bin_o` is 0 and `invalid_o` is 0. The reset is asynchronous and active low.
- R5: A lone nonzero digit d in nibble position k, with all other nibbles 0, gives exactly d times 10^k. This holds for every d from 1 to 9 and every position.
- R6: The result width defaults to the smallest width that holds the largest decimal input (17 bits for five digits). The all-nines input gives 99999, which is 0x1869F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bcd_i | input | 4*DIGITS (20) | Packed decimal digits, ones digit in bits 3:0 |
| bin_o | output | BIN_W (17) | Binary value of the digits, one cycle after capture |
| invalid_o | output | 1 | Set when a captured nibble exceeded nine |

## Verification
The hard case is a correction cell seeing a nibble of eight or more deep inside the array. This happens only when particular carries line up across neighbouring digits, and no single pattern reaches it at every digit and every stage. The stimulus therefore walks the whole decimal range 0 to 99999, one value per cycle. It adds single-digit-per-position patterns and every out-of-range nibble at each position. A mid-cycle input change and a reset asserted mid-run show that the register rank alone sets what appears at the outputs.

// File: rtl/bcd2bin_pkg.sv
package bcd2bin_pkg;

   // 10 raised to n, for small n
   function automatic longint unsigned pow10(input int unsigned n);
      longint unsigned acc;
      acc = 64'd1;
      for (int unsigned i = 0; i < n; i++) begin
         acc = acc * 64'd10;
      end
      return acc;
   endfunction

   // number of bits needed to hold v (at least one)
   function automatic int unsigned min_bits(input longint unsigned v);
      longint unsigned t;
      int unsigned     n;
      t = v;
      n = 0;
      while (t != 64'd0) begin
         n++;
         t = t >> 1;
      end
      return (n == 0) ? 1 : n;
   endfunction

   localparam int unsigned NIB_W   = 4;
   localparam int unsigned MAX_DIG = 9;

endpackage

// File: rtl/bcd_sub3_cell.sv
// Inverse correction cell: a nibble of eight or more loses three.
// Nibbles of 5..7 never reach a correction point, so bit 3 alone
// decides; 0..4 pass through untouched.
module bcd_sub3_cell
   import bcd2bin_pkg::*;
(
   input  logic [NIB_W-1:0] nib_i,
   output logic [NIB_W-1:0] nib_o
);

   always_comb begin
      if (nib_i[NIB_W-1]) begin
         nib_o = nib_i - NIB_W'(3);
      end else begin
         nib_o = nib_i;
      end
   end

endmodule

// File: rtl/bcd2bin_stage.sv
// One conversion step: shift the digit field right by one, hand the
// bit that drops out to the binary result, then correct each digit.
module bcd2bin_stage
   import bcd2bin_pkg::*;
#(
   parameter int unsigned DIGITS  = 5,
   parameter bit          CORRECT = 1'b1
)(
   input  logic [NIB_W*DIGITS-1:0] dig_i,
   output logic [NIB_W*DIGITS-1:0] dig_o,
   output logic                    lsb_o
);

   localparam int unsigned DW = NIB_W * DIGITS;

   logic [DW-1:0] shifted;

   assign shifted = {1'b0, dig_i[DW-1:1]};
   assign lsb_o   = dig_i[0];

   generate
      if (CORRECT) begin : g_fix
         for (genvar d = 0; d < DIGITS; d++) begin : g_dig
            bcd_sub3_cell i_cell (
               .nib_i (shifted[d*NIB_W +: NIB_W]),
               .nib_o (dig_o[d*NIB_W +: NIB_W])
            );
         end
      end else begin : g_pass
         assign dig_o = shifted;
      end
   endgenerate

endmodule

// File: rtl/bcd_digit_check.sv
// Flags any nibble above nine.
module bcd_digit_check
   import bcd2bin_pkg::*;
#(
   parameter int unsigned DIGITS = 5
)(
   input  logic [NIB_W*DIGITS-1:0] dig_i,
   output logic                    bad_o
);

   logic [DIGITS-1:0] over;

   generate
      for (genvar d = 0; d < DIGITS; d++) begin : g_dig
         assign over[d] = (dig_i[d*NIB_W +: NIB_W] > NIB_W'(MAX_DIG));
      end
   endgenerate

   assign bad_o = |over;

endmodule

// File: rtl/bcd2bin_core.sv
// Combinational conversion array: BIN_W stages, the last without
// correction (its correction would act on an emptied field).
module bcd2bin_core
   import bcd2bin_pkg::*;
#(
   parameter int unsigned DIGITS = 5,
   parameter int unsigned BIN_W  = 17
)(
   input  logic [NIB_W*DIGITS-1:0] dig_i,
   output logic [BIN_W-1:0]        bin_o,
   output logic                    bad_o
);

   localparam int unsigned DW    = NIB_W * DIGITS;
   localparam int unsigned STEPS = BIN_W;

   logic [DW-1:0]    chain [0:STEPS];
   logic [STEPS-1:0] taps;
   logic             digit_bad;
   logic             residue;

   assign chain[0] = dig_i;

   generate
      for (genvar s = 0; s < STEPS; s++) begin : g_step
         bcd2bin_stage #(
            .DIGITS  (DIGITS),
            .CORRECT (s != STEPS - 1)
         ) i_stage (
            .dig_i (chain[s]),
            .dig_o (chain[s+1]),
            .lsb_o (taps[s])
         );
      end
   endgenerate

   bcd_digit_check #(
      .DIGITS (DIGITS)
   ) i_dchk (
      .dig_i (dig_i),
      .bad_o (digit_bad)
   );

   // A valid input always empties the field; leftovers mean bad digits.
   assign residue = |chain[STEPS];
   assign bin_o   = taps;
   assign bad_o   = digit_bad | residue;

endmodule

// File: rtl/bcd_to_bin_conv.sv
module bcd_to_bin_conv
   import bcd2bin_pkg::*;
#(
   parameter int unsigned DIGITS       = 5,
   parameter int unsigned BIN_W        = min_bits(pow10(DIGITS) - 64'd1),
   parameter bit          REG_AT_INPUT = 1'b0
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NIB_W*DIGITS-1:0] bcd_i,
   output logic [BIN_W-1:0]        bin_o,
   output logic                    invalid_o
);

   localparam int unsigned DW       = NIB_W * DIGITS;
   localparam int unsigned NEED_W   = min_bits(pow10(DIGITS) - 64'd1);

   generate
      if (DIGITS < 1 || DIGITS > 9) begin : g_bad_digits
         $error("bcd_to_bin_conv: DIGITS must lie in 1..9");
      end
      if (BIN_W < NEED_W) begin : g_bad_width
         $error("bcd_to_bin_conv: BIN_W too small for DIGITS");
      end
   endgenerate

   generate
      if (REG_AT_INPUT) begin : g_in_reg
         logic [DW-1:0] dig_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dig_q <= '0;
            end else begin
               dig_q <= bcd_i;
            end
         end

         bcd2bin_core #(
            .DIGITS (DIGITS),
            .BIN_W  (BIN_W)
         ) i_core (
            .dig_i (dig_q),
            .bin_o (bin_o),
            .bad_o (invalid_o)
         );
      end else begin : g_out_reg
         logic [BIN_W-1:0] bin_d;
         logic             bad_d;

         bcd2bin_core #(
            .DIGITS (DIGITS),
            .BIN_W  (BIN_W)
         ) i_core (
            .dig_i (bcd_i),
            .bin_o (bin_d),
            .bad_o (bad_d)
         );

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               bin_o     <= '0;
               invalid_o <= 1'b0;
            end else begin
               bin_o     <= bin_d;
               invalid_o <= bad_d;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/bcd_to_bin_conv_chk.sv
module bcd_to_bin_conv_chk
   import bcd2bin_pkg::*;
#(
   parameter int unsigned DIGITS = 5,
   parameter int unsigned BIN_W  = 17
)(
   input logic                    clk,
   input logic                    rst_n,
   input logic [NIB_W*DIGITS-1:0] bcd_i,
   input logic [BIN_W-1:0]        bin_o,
   input logic                    invalid_o
);

   localparam longint unsigned MAX_VAL = pow10(DIGITS) - 64'd1;

   bit   rst_seen;
   logic armed;
   logic in_bad;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rst_seen <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
      end else begin
         armed <= 1'b1;
      end
   end

   always_comb begin
      in_bad = 1'b0;
      for (int d = 0; d < int'(DIGITS); d++) begin
         if (bcd_i[d*NIB_W +: NIB_W] > NIB_W'(MAX_DIG)) begin
            in_bad = 1'b1;
         end
      end
   end

   // R4
   rst_zero_chk: assert property (@(posedge clk)
      (rst_seen && !rst_n) |-> (bin_o == '0 && !invalid_o));

   // R2
   zero_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(bcd_i) == '0) |-> (bin_o == '0 && !invalid_o));

   // R3
   bad_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(in_bad)) |-> invalid_o);

   // R3
   good_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(in_bad)) |-> !invalid_o);

   // R1
   in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !invalid_o) |-> (64'(bin_o) <= MAX_VAL));

   // R1
   parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(in_bad)) |-> (bin_o[0] == $past(bcd_i[0])));

endmodule

bind bcd_to_bin_conv bcd_to_bin_conv_chk #(
   .DIGITS (DIGITS),
   .BIN_W  (BIN_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bcd_i     (bcd_i),
   .bin_o     (bin_o),
   .invalid_o (invalid_o)
);

// File: tb/test_bcd_to_bin_conv.sv
`timescale 1ns/1ps
module test_bcd_to_bin_conv;

   localparam int DIGITS = 5;
   localparam int BIN_W  = 17;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [4*DIGITS-1:0] bcd_i = '0;
   logic [BIN_W-1:0]    bin_o;
   logic                invalid_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   bcd_to_bin_conv i_bcd_to_bin_conv (
      .clk       (clk),
      .rst_n     (rst_n),
      .bcd_i     (bcd_i),
      .bin_o     (bin_o),
      .invalid_o (invalid_o)
   );

   function automatic logic [4*DIGITS-1:0] to_bcd(input int v);
      logic [4*DIGITS-1:0] r;
      int t;
      t = v;
      r = '0;
      for (int k = 0; k < DIGITS; k++) begin
         r[4*k +: 4] = 4'(t % 10);
         t = t / 10;
      end
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic t_reset();
      bcd_i = to_bcd(777);
      repeat (3) @(negedge clk);
      chk(bin_o == '0, "R4 bin in reset", int'(bin_o), 0);
      chk(invalid_o == 1'b0, "R4 flag in reset", int'(invalid_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(int'(bin_o) == 777, "R2 first capture", int'(bin_o), 777);
   endtask

   task automatic t_sweep();
      int prev;
      prev = -1;
      for (int v = 0; v <= 100000; v++) begin
         @(negedge clk);
         if (prev >= 0) begin
            chk(int'(bin_o) == prev && !invalid_o, "R1 sweep", int'(bin_o), prev);
         end
         if (v < 100000) begin
            bcd_i = to_bcd(v);
            prev  = v;
         end
      end
   endtask

   task automatic t_positions();
      int w;
      w = 1;
      for (int p = 0; p < DIGITS; p++) begin
         for (int d = 1; d <= 9; d++) begin
            @(negedge clk);
            bcd_i = '0;
            bcd_i[4*p +: 4] = 4'(d);
            @(negedge clk);
            chk(int'(bin_o) == d * w, "R5 single digit", int'(bin_o), d * w);
         end
         w = w * 10;
      end
   endtask

   task automatic t_invalid();
      for (int p = 0; p < DIGITS; p++) begin
         for (int n = 10; n <= 15; n++) begin
            @(negedge clk);
            bcd_i = to_bcd(12345);
            bcd_i[4*p +: 4] = 4'(n);
            @(negedge clk);
            chk(invalid_o == 1'b1, "R3 bad nibble", int'(invalid_o), 1);
         end
      end
      @(negedge clk);
      bcd_i = to_bcd(99999);
      @(negedge clk);
      chk(invalid_o == 1'b0, "R3 flag clears", int'(invalid_o), 0);
      chk(int'(bin_o) == 99999 && bin_o == 17'h1869F, "R6 all nines", int'(bin_o), 99999);
      chk($bits(bin_o) == 17, "R6 width", $bits(bin_o), 17);
   endtask

   task automatic t_latency();
      @(negedge clk);
      bcd_i = to_bcd(12345);
      @(posedge clk);
      #1;
      bcd_i = to_bcd(54321);
      #1;
      chk(int'(bin_o) == 12345, "R2 holds mid-cycle", int'(bin_o), 12345);
      @(negedge clk);
      chk(int'(bin_o) == 12345, "R2 holds to edge", int'(bin_o), 12345);
      @(posedge clk);
      #1;
      chk(int'(bin_o) == 54321, "R2 next edge", int'(bin_o), 54321);
   endtask

   task automatic t_midreset();
      @(negedge clk);
      bcd_i = to_bcd(98765);
      @(negedge clk);
      chk(int'(bin_o) == 98765, "R1 before reset", int'(bin_o), 98765);
      rst_n = 1'b0;
      #1;
      chk(bin_o == '0 && !invalid_o, "R4 async clear", int'(bin_o), 0);
      @(negedge clk);
      chk(bin_o == '0, "R4 held over edge", int'(bin_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(int'(bin_o) == 98765, "R2 after release", int'(bin_o), 98765);
   endtask

   initial begin
      t_reset();
      t_latency();
      t_positions();
      t_invalid();
      t_midreset();
      t_sweep();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule